// File: doc/BRIEF.md
# ECP Reverse-Channel Receiver with Run-Length Expansion

This block is the host side of an extended-capability parallel port link when the peripheral is the one sending. On request it brings a forward-idle port into ECP mode and turns the data bus around so the peripheral drives it. It then takes one byte per interlocked handshake. The peripheral pulls its strobe line (`ack_n_i`) low, and the host answers by raising its own acknowledge line (`autofd_n_o`). The level of `busy_i` at strobe time marks the byte as data (high) or as a command (low).

A command byte with its top bit clear holds a run count, and the next data byte is then delivered count+1 times on a valid/ready byte stream. A command byte with the top bit set is a channel address and is dropped. A second request turns the bus back to the forward direction. Every wait on the peripheral is bounded by a tick count. When a bound runs out, `err_o` is set and the machine parks in idle with the bus direction it had at that moment.

The states are IDLE, ENTRY (wait for entry reply), SETUP (setup delay after the direction change), REV_WAIT (wait for the peripheral to take the bus), WAIT_ACK (wait for a byte strobe), ACK_HI (acknowledge raised), EMIT (delivering the byte and its repeats) and FWD_WAIT (wait for the peripheral to release the bus). The transitions are:

- IDLE to ENTRY on a reverse request in the forward direction.
- IDLE to WAIT_ACK on a reverse request when already reversed.
- IDLE to FWD_WAIT on a forward request when reversed.
- ENTRY to SETUP on `perror_i` high.
- SETUP to REV_WAIT after the setup ticks.
- REV_WAIT to WAIT_ACK on `perror_i` low.
- WAIT_ACK to ACK_HI on strobe low.
- WAIT_ACK to FWD_WAIT on a forward request.
- ACK_HI to EMIT (byte pending) or to WAIT_ACK (command) on strobe high.
- EMIT to WAIT_ACK when the last copy is accepted.
- FWD_WAIT to IDLE on `perror_i` high.
- Any waiting state to IDLE on timeout.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, `dir_in_o`=0, `autofd_n_o`=1, `init_n_o`=1, `out_valid_o`=0 and `err_o`=0.
- R2: A pulse on `start_rev_i` in the forward direction drives `autofd_n_o` low with `dir_in_o` still 0. The block then waits up to RESP_TICKS ticks for `perror_i` high.
- R3: Once `perror_i` is high, `dir_in_o` becomes 1 with `autofd_n_o` low and `init_n_o` high. After SETUP_TICKS ticks `init_n_o` goes low, and the block waits up to RESP_TICKS ticks for `perror_i` low before accepting bytes.
- R4: With `ack_n_i` low and `busy_i`=1, the byte on `data_i` is captured. `autofd_n_o` rises and stays high until `ack_n_i` returns high, then falls. The byte is then delivered on `out_data_o`.
- R5: A command byte (`busy_i`=0) with bit 7 = 0 loads bits 6:0 as a run count N. The next data byte is delivered N+1 times in a row.
- R6: A command byte with bit 7 = 1 is acknowledged but produces no output and leaves a pending run count unchanged.
- R7: A run count is used by one data byte only. The data byte after it is delivered once.
- R8: While `out_valid_o`=1 and `out_ready_i`=0, `out_data_o` is held. While copies remain to be delivered, `autofd_n_o` stays low and a new strobe is not answered.
- R9: A pulse on `start_fwd_i` in the reverse direction raises `init_n_o` and waits up to RESP_TICKS ticks for `perror_i` high. Then `autofd_n_o` goes high and `dir_in_o` goes 0 in the same cycle.
- R10: If a bounded wait runs out, `err_o` is set and the block returns to idle with `dir_in_o` unchanged. The next accepted request clears `err_o`.
- R11: The wait for a byte strobe is bounded by IDLE_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base pulse that advances the wait counters |
| start_rev_i | input | 1 | Request ECP entry, reverse turnaround and reception |
| start_fwd_i | input | 1 | Request turnaround back to forward |
| ack_n_i | input | 1 | Peripheral byte strobe, active low |
| busy_i | input | 1 | Data (1) / command (0) marker |
| perror_i | input | 1 | Peripheral turnaround acknowledge line |
| data_i | input | 8 | Data bus from the peripheral |
| autofd_n_o | output | 1 | Host acknowledge line |
| init_n_o | output | 1 | Host bus-direction request line |
| dir_in_o | output | 1 | 1 = data bus is input to the host |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Output byte accepted |
| err_o | output | 1 | Timeout flag |

## Verification
Repeat delivery and the byte handshake can meet in the same cycle. A strobe for the next byte can already be low when the last copy of a run is accepted. The bench stalls the output, drives the next byte's strobe while copies remain, and confirms that `autofd_n_o` stays low and `out_data_o` is unchanged. It then releases `out_ready_i` and checks that the new byte follows the full run, with none lost and none doubled.

// File: rtl/ecp_rev_rx_pkg.sv
package ecp_rev_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ENTRY,
        S_SETUP,
        S_REV_WAIT,
        S_WAIT_ACK,
        S_ACK_HI,
        S_EMIT,
        S_FWD_WAIT
    } rx_state_t;
endpackage

// File: rtl/ecp_rev_rx_timer.sv
module ecp_rev_rx_timer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (tick_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = tick_i && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/ecp_rev_rx_rle.sv
module ecp_rev_rx_rle #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          cap_i,
    input  logic          is_data_i,
    input  logic [DW-1:0] byte_i,
    input  logic          pop_i,
    output logic          pending_o,
    output logic          last_o,
    output logic [DW-1:0] byte_o
);
    localparam int RW = DW - 1;

    logic [RW-1:0] run_q;
    logic [RW-1:0] rem_q;
    logic [DW-1:0] byte_q;
    logic          pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            rem_q  <= '0;
            byte_q <= '0;
            pend_q <= 1'b0;
        end else if (flush_i) begin
            run_q  <= '0;
            rem_q  <= '0;
            pend_q <= 1'b0;
        end else if (cap_i) begin
            if (is_data_i) begin
                byte_q <= byte_i;
                rem_q  <= run_q;
                run_q  <= '0;
                pend_q <= 1'b1;
            end else if (!byte_i[DW-1]) begin
                run_q <= byte_i[RW-1:0];
            end
        end else if (pop_i && pend_q) begin
            if (rem_q == '0) pend_q <= 1'b0;
            else             rem_q  <= rem_q - 1'b1;
        end
    end

    assign pending_o = pend_q;
    assign last_o    = (rem_q == '0);
    assign byte_o    = byte_q;
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
    import ecp_rev_rx_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SETUP_TICKS = 1,
    parameter int RESP_TICKS  = 6,
    parameter int IDLE_TICKS  = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          start_rev_i,
    input  logic          start_fwd_i,
    input  logic          ack_n_i,
    input  logic          busy_i,
    input  logic          perror_i,
    input  logic [DW-1:0] data_i,
    output logic          autofd_n_o,
    output logic          init_n_o,
    output logic          dir_in_o,
    output logic          out_valid_o,
    output logic [DW-1:0] out_data_o,
    input  logic          out_ready_i,
    output logic          err_o
);
    localparam int MAXT = (IDLE_TICKS > RESP_TICKS) ?
                          ((IDLE_TICKS > SETUP_TICKS) ? IDLE_TICKS : SETUP_TICKS) :
                          ((RESP_TICKS > SETUP_TICKS) ? RESP_TICKS : SETUP_TICKS);
    localparam int CW = $clog2(MAXT + 1);
    localparam logic [CW-1:0] LIM_SETUP = CW'(SETUP_TICKS);
    localparam logic [CW-1:0] LIM_RESP  = CW'(RESP_TICKS);
    localparam logic [CW-1:0] LIM_IDLE  = CW'(IDLE_TICKS);

    rx_state_t     state_q, state_d;
    logic          dir_q, err_q;
    logic          timeout;
    logic [CW-1:0] limit;
    logic          expired;
    logic          state_chg;
    logic          cap, pop, flush;
    logic          pending, last;
    logic [DW-1:0] emit_byte;

    assign state_chg = (state_d != state_q);

    ecp_rev_rx_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (state_chg),
        .tick_i    (tick_i),
        .limit_i   (limit),
        .expired_o (expired)
    );

    ecp_rev_rx_rle #(.DW(DW)) u_rle (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .cap_i     (cap),
        .is_data_i (busy_i),
        .byte_i    (data_i),
        .pop_i     (pop),
        .pending_o (pending),
        .last_o    (last),
        .byte_o    (emit_byte)
    );

    assign pop   = out_valid_o && out_ready_i;
    assign flush = state_chg && ((state_d == S_IDLE) || (state_d == S_FWD_WAIT));

    // next-state logic
    always_comb begin
        state_d = state_q;
        timeout = 1'b0;
        cap     = 1'b0;
        limit   = LIM_RESP;
        unique case (state_q)
            S_IDLE: begin
                if (start_rev_i)
                    state_d = dir_q ? S_WAIT_ACK : S_ENTRY;
                else if (start_fwd_i && dir_q)
                    state_d = S_FWD_WAIT;
            end
            S_ENTRY: begin
                if (perror_i)     state_d = S_SETUP;
                else if (expired) timeout = 1'b1;
            end
            S_SETUP: begin
                limit = LIM_SETUP;
                if (expired) state_d = S_REV_WAIT;
            end
            S_REV_WAIT: begin
                if (!perror_i)    state_d = S_WAIT_ACK;
                else if (expired) timeout = 1'b1;
            end
            S_WAIT_ACK: begin
                limit = LIM_IDLE;
                if (!ack_n_i) begin
                    state_d = S_ACK_HI;
                    cap     = 1'b1;
                end else if (start_fwd_i) begin
                    state_d = S_FWD_WAIT;
                end else if (expired) begin
                    timeout = 1'b1;
                end
            end
            S_ACK_HI: begin
                if (ack_n_i)      state_d = pending ? S_EMIT : S_WAIT_ACK;
                else if (expired) timeout = 1'b1;
            end
            S_EMIT: begin
                if (out_ready_i && last) state_d = S_WAIT_ACK;
            end
            S_FWD_WAIT: begin
                if (perror_i)     state_d = S_IDLE;
                else if (expired) timeout = 1'b1;
            end
            default: state_d = S_IDLE;
        endcase
        if (timeout) state_d = S_IDLE;
    end

    // state register, direction and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dir_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_ENTRY && state_d == S_SETUP)
                dir_q <= 1'b1;
            else if (state_q == S_FWD_WAIT && state_d == S_IDLE && !timeout)
                dir_q <= 1'b0;
            if (timeout)
                err_q <= 1'b1;
            else if (state_q == S_IDLE && state_d != S_IDLE)
                err_q <= 1'b0;
        end
    end

    // outputs from state
    always_comb begin
        autofd_n_o  = 1'b0;
        init_n_o    = 1'b0;
        dir_in_o    = 1'b1;
        out_valid_o = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                autofd_n_o = !dir_q;
                init_n_o   = !dir_q;
                dir_in_o   = dir_q;
            end
            S_ENTRY: begin
                init_n_o = 1'b1;
                dir_in_o = 1'b0;
            end
            S_SETUP:    init_n_o    = 1'b1;
            S_REV_WAIT: init_n_o    = 1'b0;
            S_WAIT_ACK: init_n_o    = 1'b0;
            S_ACK_HI:   autofd_n_o  = 1'b1;
            S_EMIT:     out_valid_o = 1'b1;
            S_FWD_WAIT: init_n_o    = 1'b1;
            default: ;
        endcase
    end

    assign out_data_o = emit_byte;
    assign err_o      = err_q;
endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_n_i,
    input logic          autofd_n_o,
    input logic          init_n_o,
    input logic          dir_in_o,
    input logic          out_valid_o,
    input logic [DW-1:0] out_data_o,
    input logic          out_ready_i,
    input logic          err_o
);
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R8
    AST_OUT_LEAVES_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid_o) |-> $past(out_ready_i)); // R8
    AST_ACK_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(autofd_n_o) && dir_in_o |-> $past(!ack_n_i)); // R4
    AST_TURN_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir_in_o) |-> !autofd_n_o && init_n_o); // R3
    AST_FWD_INIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_in_o |-> init_n_o && !out_valid_o); // R9
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !out_valid_o && $stable(dir_in_o)); // R10
endmodule

bind ecp_rev_rx ecp_rev_rx_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_n_i     (ack_n_i),
    .autofd_n_o  (autofd_n_o),
    .init_n_o    (init_n_o),
    .dir_in_o    (dir_in_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .err_o       (err_o)
);

// File: tb/tb_ecp_rev_rx.sv
module tb_ecp_rev_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       start_rev = 1'b0, start_fwd = 1'b0;
    logic       ack_n = 1'b1, busy = 1'b0, perror = 1'b0;
    logic [7:0] data = 8'h00;
    logic       out_ready = 1'b1;
    logic       autofd_n, init_n, dir_in, out_valid, err;
    logic [7:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] got[$];
    logic [7:0] expq[$];

    always #4 clk = ~clk;

    ecp_rev_rx dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .start_rev_i(start_rev), .start_fwd_i(start_fwd),
        .ack_n_i(ack_n), .busy_i(busy), .perror_i(perror), .data_i(data),
        .autofd_n_o(autofd_n), .init_n_o(init_n), .dir_in_o(dir_in),
        .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
        .err_o(err)
    );

    always @(negedge clk)
        if (rst_n && out_valid && out_ready) got.push_back(out_data);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic bsy, input logic [7:0] d, input string tag);
        bit seen = 0;
        busy = bsy; data = d; ack_n = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            step();
            if (autofd_n) seen = 1;
        end
        chk(seen, {tag, " ack raised"}, autofd_n, 1);
        ack_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            step();
            if (!autofd_n) seen = 1;
        end
        chk(seen, {tag, " ack lowered"}, autofd_n, 0);
    endtask

    task automatic check_stream(input string tag);
        for (int i = 0; i < 10; i++) step();
        chk(got.size() == expq.size(), {tag, " count"}, got.size(), expq.size());
        for (int i = 0; i < expq.size() && i < got.size(); i++)
            chk(got[i] == expq[i], {tag, " byte"}, got[i], expq[i]);
        got.delete();
        expq.delete();
    endtask

    task automatic t_reset();
        chk(dir_in == 0 && autofd_n == 1 && init_n == 1, "R1 pins",
            {dir_in, autofd_n, init_n}, 3'b011);
        chk(out_valid == 0 && err == 0, "R1 valid/err", {out_valid, err}, 0);
    endtask

    task automatic t_reverse();
        bit seen = 0;
        start_rev = 1'b1; step(); start_rev = 1'b0;
        chk(autofd_n == 0 && dir_in == 0, "R2 entry pins", {autofd_n, dir_in}, 0);
        perror = 1'b1; step();
        chk(dir_in == 1 && autofd_n == 0 && init_n == 1, "R3 turn pins",
            {dir_in, autofd_n, init_n}, 3'b101);
        for (int i = 0; i < 5 && !seen; i++) begin
            step();
            if (!init_n) seen = 1;
        end
        chk(seen, "R3 init low", init_n, 0);
        perror = 1'b0;
        for (int i = 0; i < 10; i++) step();
        chk(err == 0 && dir_in == 1, "R3 no error", {err, dir_in}, 2'b01);
    endtask

    task automatic t_plain();
        send(1'b1, 8'h3C, "R4");
        send(1'b1, 8'hA5, "R4");
        expq.push_back(8'h3C); expq.push_back(8'hA5);
        check_stream("R4 stream");
    endtask

    task automatic t_rle();
        send(1'b0, 8'h03, "R5");
        send(1'b1, 8'h77, "R5");
        send(1'b1, 8'h11, "R7");
        for (int i = 0; i < 4; i++) expq.push_back(8'h77);
        expq.push_back(8'h11);
        check_stream("R5 R7 stream");
    endtask

    task automatic t_channel();
        send(1'b0, 8'h85, "R6");
        send(1'b1, 8'h22, "R6");
        send(1'b0, 8'h02, "R6");
        send(1'b0, 8'h90, "R6");
        send(1'b1, 8'h44, "R6");
        expq.push_back(8'h22);
        for (int i = 0; i < 3; i++) expq.push_back(8'h44);
        check_stream("R6 stream");
    endtask

    task automatic t_backpressure();
        bit seen = 0;
        out_ready = 1'b0;
        send(1'b0, 8'h01, "R8");
        send(1'b1, 8'h5A, "R8");
        for (int i = 0; i < 4; i++) step();
        chk(out_valid && out_data == 8'h5A, "R8 held", out_data, 8'h5A);
        busy = 1'b1; data = 8'h66; ack_n = 1'b0;
        for (int i = 0; i < 3; i++) step();
        chk(autofd_n == 0, "R8 no ack during repeats", autofd_n, 0);
        chk(out_data == 8'h5A, "R8 data stable", out_data, 8'h5A);
        out_ready = 1'b1;
        for (int i = 0; i < 20 && !seen; i++) begin
            step();
            if (autofd_n) seen = 1;
        end
        chk(seen, "R8 next strobe answered", autofd_n, 1);
        ack_n = 1'b1;
        for (int i = 0; i < 3; i++) step();
        expq.push_back(8'h5A); expq.push_back(8'h5A); expq.push_back(8'h66);
        check_stream("R8 stream");
    endtask

    task automatic t_forward();
        start_fwd = 1'b1; step(); start_fwd = 1'b0;
        chk(init_n == 1 && autofd_n == 0 && dir_in == 1, "R9 request pins",
            {init_n, autofd_n, dir_in}, 3'b101);
        perror = 1'b1; step();
        chk(autofd_n == 1 && dir_in == 0 && err == 0, "R9 forward done",
            {autofd_n, dir_in, err}, 3'b100);
    endtask

    task automatic t_timeouts();
        start_rev = 1'b1; step(); start_rev = 1'b0;
        for (int i = 0; i < 20; i++) step();
        chk(err == 1 && dir_in == 1, "R10 timeout dir held", {err, dir_in}, 2'b11);
        perror = 1'b0;
        start_rev = 1'b1; step(); start_rev = 1'b0;
        chk(err == 0, "R10 error cleared", err, 0);
        for (int i = 0; i < 1990; i++) step();
        chk(err == 0, "R11 before bound", err, 0);
        for (int i = 0; i < 20; i++) step();
        chk(err == 1 && dir_in == 1, "R11 after bound", {err, dir_in}, 2'b11);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_reverse();
        t_plain();
        t_rle();
        t_channel();
        t_backpressure();
        t_forward();
        t_timeouts();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule